// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block is the slave-side instruction engine of a serial EEPROM with a four-wire synchronous serial interface. A host lowers chip select, shifts in an 8-bit opcode and, depending on the opcode, a 16-bit address and data bytes, or clocks out data. The controller decodes six instructions. It keeps a write-enable latch and a small status register, and it reads and writes an internal byte array held as a register file. After each accepted modification it reports busy for a programmable number of clock cycles.

The serial pins are sampled in the core clock domain. Chip select, serial clock and serial in each pass through one register, and their edges are found against the previous sample. The serial clock idles low. Input bits are taken on its rising edge, output bits change on its falling edge, and every field travels most significant bit first. Array writes are collected in a page buffer and stored in one step when chip select rises, provided the transfer ended on a byte boundary and the write latch was set. DEPTH must be a power of two.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset so_oe and busy are 0, and the status byte reads 0x00.
- R2: An opcode is accepted only when its upper four bits are 0. Bit 3 is ignored, and bits 2:0 select the instruction: 110 set latch, 100 clear latch, 101 status read, 001 status write, 011 array read, 010 array write. Any other code leaves so_oe at 0, and chip select rising afterwards changes nothing.
- R3: The set-latch and clear-latch opcodes set and clear the write latch when chip select rises after exactly 8 bits. The latch is status bit 1.
- R4: An array write or status write issued while the write latch is 0 changes neither the array nor the status register, and starts no busy period.
- R5: An array write (opcode, 16-bit address, data bytes) stores its bytes at consecutive addresses and clears the latch, but only when chip select rises after a whole number of data bytes. A transfer that ends mid-byte is discarded and leaves the latch as it was.
- R6: An array read (opcode, 16-bit address) streams bytes from the address taken modulo DEPTH and increments after each byte. The address wraps from DEPTH-1 to 0.
- R7: The status read outputs the status byte {protect bit 7, 0, 0, 0, block bits 3:2, latch bit 1, busy bit 0}, repeated for every further 8 clocks. The first bit appears after the first falling clock edge following the opcode.
- R8: The status write takes one data byte and changes only status bits 7, 3 and 2. It then clears the latch.
- R9: A committed array or status write drives busy, and status bit 0, high for exactly WR_CYCLES clock cycles from the chip select rise.
- R10: While busy, every opcode other than the status read is ignored. A set-latch request therefore leaves the latch at 0.
- R11: An array write keeps only its first PAGE data bytes. Bytes after those are dropped.
- R12: so_oe is 1 only during the output phase of a status read or an array read, and it is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for so |
| busy | output | 1 | Internal write cycle running |

## Verification
The opcodes are exercised in several forms: exact-length, with stray bits appended, with bit 3 set, with the upper nibble set, and arriving during a busy period. These separate decode faults from commit-gating faults. Array writes are sent as a short burst, a burst longer than the page, a burst ending mid-byte, and a burst to the last addresses. Reading each back shows whether address increment, wrap, page truncation and the alignment rule hold. Status writes use patterns with the masked bits set, and repeated status reads show both the stable byte and the busy bit.

// File: rtl/ee_pkg.sv
package ee_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_WDAT,
        ST_SROUT, ST_SRIN, ST_HOLD, ST_DROP
    } st_e;

    typedef enum logic [2:0] {
        OP_BAD, OP_WR_EN, OP_WR_DIS, OP_STAT_RD,
        OP_STAT_WR, OP_ARR_RD, OP_ARR_WR
    } op_e;

    function automatic op_e decode_op(input logic [7:0] code);
        op_e r;
        r = OP_BAD;
        if (code[7:4] == 4'h0) begin
            case (code[2:0])
                3'b110:  r = OP_WR_EN;
                3'b100:  r = OP_WR_DIS;
                3'b101:  r = OP_STAT_RD;
                3'b001:  r = OP_STAT_WR;
                3'b011:  r = OP_ARR_RD;
                3'b010:  r = OP_ARR_WR;
                default: r = OP_BAD;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ee_pin_sync.sv
module ee_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic si,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_rise,
    output logic cs_fall,
    output logic cs_prev,
    output logic si_s
);
    typedef struct packed {
        logic sck;
        logic sck_p;
        logic cs;
        logic cs_p;
        logic din;
    } pin_t;

    pin_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.sck   = sclk;
        p_d.sck_p = p_q.sck;
        p_d.cs    = cs_n;
        p_d.cs_p  = p_q.cs;
        p_d.din   = si;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{sck: 1'b0, sck_p: 1'b0, cs: 1'b1, cs_p: 1'b1, din: 1'b0};
        else        p_q <= p_d;
    end

    assign sclk_rise = p_q.sck & ~p_q.sck_p;
    assign sclk_fall = ~p_q.sck & p_q.sck_p;
    assign cs_rise   = p_q.cs & ~p_q.cs_p;
    assign cs_fall   = ~p_q.cs & p_q.cs_p;
    assign cs_prev   = p_q.cs_p;
    assign si_s      = p_q.din;
endmodule

// File: rtl/ee_store.sv
module ee_store #(
    parameter int DEPTH = 64,
    parameter int PAGE  = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(PAGE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_idx,
    output logic [7:0]        rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_base,
    input  logic [CW-1:0]     wr_cnt,
    input  logic [PAGE*8-1:0] wr_buf
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            for (int i = 0; i < PAGE; i++) begin
                if (CW'(i) < wr_cnt) mem_d[wr_base + AW'(i)] = wr_buf[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl #(
    parameter int DEPTH     = 64,
    parameter int PAGE      = 8,
    parameter int WR_CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic si,
    output logic so,
    output logic so_oe,
    output logic busy
);
    import ee_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(PAGE + 1);
    localparam int BW = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [3:0]        bitc;
        logic [15:0]       sh;
        logic [AW-1:0]     addr;
        logic              wlatch;
        logic              pe;
        logic [1:0]        bp;
        logic [BW-1:0]     bcnt;
        logic [2:0]        obit;
        logic [7:0]        obuf;
        logic              so;
        logic [PAGE*8-1:0] wbuf;
        logic [CW-1:0]     wcnt;
    } regs_t;

    regs_t r_d, r_q;

    logic sclk_rise, sclk_fall, cs_rise, cs_fall, cs_prev, si_s;
    logic [7:0] rd_data;
    logic [7:0] status;
    logic [15:0] sh_n;
    logic [7:0] src;
    logic arr_commit, any_commit;
    logic wlatch;
    logic [BW-1:0] busy_cnt;

    ee_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_rise(cs_rise), .cs_fall(cs_fall), .cs_prev(cs_prev), .si_s(si_s)
    );

    ee_store #(.DEPTH(DEPTH), .PAGE(PAGE)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(r_q.addr), .rd_data(rd_data),
        .wr_en(arr_commit), .wr_base(r_q.addr),
        .wr_cnt(r_q.wcnt), .wr_buf(r_q.wbuf)
    );

    assign busy   = (r_q.bcnt != '0);
    assign status = {r_q.pe, 3'b000, r_q.bp, r_q.wlatch, busy};
    assign sh_n   = {r_q.sh[14:0], si_s};
    assign src    = (r_q.st == ST_SROUT) ? status : rd_data;

    always_comb begin
        r_d        = r_q;
        arr_commit = 1'b0;
        any_commit = 1'b0;
        if (busy) r_d.bcnt = r_q.bcnt - BW'(1);

        if (cs_fall) begin
            r_d.st   = ST_OPC;
            r_d.bitc = '0;
            r_d.obit = '0;
            r_d.so   = 1'b0;
        end else if (cs_rise) begin
            r_d.st = ST_IDLE;
            if (r_q.st == ST_HOLD) begin
                case (r_q.op)
                    OP_WR_EN:  r_d.wlatch = 1'b1;
                    OP_WR_DIS: r_d.wlatch = 1'b0;
                    OP_STAT_WR: if (r_q.wlatch) begin
                        r_d.pe     = r_q.sh[7];
                        r_d.bp     = r_q.sh[3:2];
                        r_d.wlatch = 1'b0;
                        r_d.bcnt   = BW'(WR_CYCLES);
                        any_commit = 1'b1;
                    end
                    default: ;
                endcase
            end else if (r_q.st == ST_WDAT && r_q.bitc == '0
                         && r_q.wcnt != '0 && r_q.wlatch) begin
                arr_commit = 1'b1;
                any_commit = 1'b1;
                r_d.wlatch = 1'b0;
                r_d.bcnt   = BW'(WR_CYCLES);
            end
        end else if (sclk_rise && r_q.st != ST_IDLE) begin
            r_d.sh   = sh_n;
            r_d.bitc = r_q.bitc + 4'd1;
            case (r_q.st)
                ST_OPC: if (r_q.bitc == 4'd7) begin
                    r_d.bitc = '0;
                    r_d.op   = decode_op(sh_n[7:0]);
                    if (busy && r_d.op != OP_STAT_RD) r_d.st = ST_DROP;
                    else begin
                        case (r_d.op)
                            OP_WR_EN, OP_WR_DIS: r_d.st = ST_HOLD;
                            OP_STAT_RD:          r_d.st = ST_SROUT;
                            OP_STAT_WR:          r_d.st = ST_SRIN;
                            OP_ARR_RD, OP_ARR_WR: r_d.st = ST_ADDR;
                            default:             r_d.st = ST_DROP;
                        endcase
                    end
                end
                ST_ADDR: if (r_q.bitc == 4'd15) begin
                    r_d.bitc = '0;
                    r_d.addr = sh_n[AW-1:0];
                    r_d.wcnt = '0;
                    r_d.st   = (r_q.op == OP_ARR_RD) ? ST_RDAT : ST_WDAT;
                end
                ST_WDAT: if (r_q.bitc == 4'd7) begin
                    r_d.bitc = '0;
                    if (r_q.wcnt < CW'(PAGE)) begin
                        for (int i = 0; i < PAGE; i++) begin
                            if (r_q.wcnt == CW'(i)) r_d.wbuf[i*8 +: 8] = sh_n[7:0];
                        end
                        r_d.wcnt = r_q.wcnt + CW'(1);
                    end
                end
                ST_SRIN: if (r_q.bitc == 4'd7) begin
                    r_d.bitc = '0;
                    r_d.st   = ST_HOLD;
                end
                ST_HOLD: r_d.st = ST_DROP;
                default: ;
            endcase
        end else if (sclk_fall && (r_q.st == ST_SROUT || r_q.st == ST_RDAT)) begin
            if (r_q.obit == '0) begin
                r_d.so   = src[7];
                r_d.obuf = src;
            end else begin
                r_d.so = r_q.obuf[3'd7 - r_q.obit];
            end
            r_d.obit = r_q.obit + 3'd1;
            if (r_q.obit == 3'd7 && r_q.st == ST_RDAT) r_d.addr = r_q.addr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign so       = r_q.so;
    assign so_oe    = (r_q.st == ST_SROUT) || (r_q.st == ST_RDAT);
    assign wlatch   = r_q.wlatch;
    assign busy_cnt = r_q.bcnt;
endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk #(
    parameter int BW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic [BW-1:0] busy_cnt,
    input logic          wlatch,
    input logic          commit,
    input logic          so_oe,
    input logic          cs_prev
);
    AST_BUSY_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wlatch); // R10

    AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != '0) |=> (busy_cnt == $past(busy_cnt) - BW'(1))); // R9

    AST_COMMIT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (wlatch && !busy)); // R4

    AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy); // R9

    AST_OE_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !cs_prev); // R12
endmodule

bind spi_eeprom_ctrl spi_eeprom_chk #(.BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .busy_cnt(busy_cnt),
    .wlatch(wlatch), .commit(any_commit), .so_oe(so_oe), .cs_prev(cs_prev)
);

// File: tb/sim_spi_eeprom_ctrl.sv
`timescale 1ns/1ps
module sim_spi_eeprom_ctrl;
    localparam int DEPTH = 64;
    localparam int PAGE  = 8;
    localparam int W     = 300;
    localparam int H     = 4;
    localparam int K_SET = 1, K_CLR = 2, K_SRD = 3, K_SWR = 4, K_RD = 5, K_WR = 6;

    logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, si = 0;
    logic so, so_oe, busy;

    always #2.5 clk = ~clk;

    spi_eeprom_ctrl #(.DEPTH(DEPTH), .PAGE(PAGE), .WR_CYCLES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
        .so(so), .so_oe(so_oe), .busy(busy)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    int busy_seen;
    bit oe_bad;

    logic [7:0] mem_m [DEPTH];
    bit wl_m = 0, pe_m = 0, busy_m = 0;
    logic [1:0] bp_m = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int mop(input logic [7:0] b);
        if (b[7:4] != 4'h0) return 0;
        case (b[2:0])
            3'b110: return K_SET;
            3'b100: return K_CLR;
            3'b101: return K_SRD;
            3'b001: return K_SWR;
            3'b011: return K_RD;
            3'b010: return K_WR;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] stat_m();
        return {pe_m, 3'b000, bp_m, wl_m, busy_m};
    endfunction

    task automatic txn(input int extra, input int nrx, input bit exp_oe, input bit measure);
        logic [7:0] b;
        rx_q.delete();
        oe_bad = 0;
        @(negedge clk); cs_n = 0; repeat (H) @(negedge clk);
        foreach (tx_q[i]) begin
            for (int k = 7; k >= 0; k--) begin
                si = tx_q[i][k]; sclk = 0; repeat (H) @(negedge clk);
                if (so_oe !== 1'b0) oe_bad = 1;
                sclk = 1; repeat (H) @(negedge clk);
            end
        end
        for (int e = 0; e < extra; e++) begin
            si = 1; sclk = 0; repeat (H) @(negedge clk);
            sclk = 1; repeat (H) @(negedge clk);
        end
        for (int n = 0; n < nrx; n++) begin
            for (int k = 7; k >= 0; k--) begin
                sclk = 0; repeat (H) @(negedge clk);
                b[k] = so;
                if (so_oe !== exp_oe) oe_bad = 1;
                sclk = 1; repeat (H) @(negedge clk);
            end
            rx_q.push_back(b);
        end
        sclk = 0; repeat (H) @(negedge clk);
        cs_n = 1;
        if (measure) begin
            busy_seen = 0;
            repeat (W + 20) begin
                @(negedge clk);
                if (busy) busy_seen++;
            end
        end else begin
            repeat (H) @(negedge clk);
            if (so_oe !== 1'b0) oe_bad = 1;
        end
    endtask

    function automatic bit apply_m(input int op, input int extra);
        int len = tx_q.size();
        int a;
        if (op == 0 || (busy_m && op != K_SRD)) return 0;
        if (op == K_SET && len == 1 && extra == 0) wl_m = 1;
        if (op == K_CLR && len == 1 && extra == 0) wl_m = 0;
        if (op == K_SWR && len == 2 && extra == 0 && wl_m) begin
            pe_m = tx_q[1][7]; bp_m = tx_q[1][3:2]; wl_m = 0;
            return 1;
        end
        if (op == K_WR && len >= 4 && extra == 0 && wl_m) begin
            a = {tx_q[1], tx_q[2]} % DEPTH;
            for (int i = 0; i < len - 3 && i < PAGE; i++) mem_m[(a + i) % DEPTH] = tx_q[3 + i];
            wl_m = 0;
            return 1;
        end
        return 0;
    endfunction

    task automatic run(input string req, input int extra, input int nrx, input bit measure);
        int op = mop(tx_q[0]);
        bit eoe = (op == K_SRD) || (op == K_RD && !busy_m);
        logic [7:0] exp_q[$];
        int a;
        bit cm;
        if (op == K_SRD) for (int i = 0; i < nrx; i++) exp_q.push_back(stat_m());
        if (op == K_RD && !busy_m) begin
            a = {tx_q[1], tx_q[2]} % DEPTH;
            for (int i = 0; i < nrx; i++) exp_q.push_back(mem_m[(a + i) % DEPTH]);
        end
        txn(extra, nrx, eoe, measure);
        chk(req, "so_oe", oe_bad, 0);
        if (eoe) foreach (exp_q[i]) chk(req, "data", rx_q[i], exp_q[i]);
        cm = apply_m(op, extra);
        if (measure) chk(req, "busy_cycles", busy_seen, cm ? W : 0);
        else if (cm) busy_m = 1;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        busy_m = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        foreach (mem_m[i]) mem_m[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk("R1", "so_oe", so_oe, 0);
        chk("R1", "busy", busy, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R1", "busy_after", busy, 0);
        tx_q = '{8'h05}; run("R1", 0, 1, 0);
        // R4: array write with latch clear
        tx_q = '{8'h02, 8'h00, 8'h05, 8'hAA, 8'hBB}; run("R4", 0, 0, 1);
        tx_q = '{8'h03, 8'h00, 8'h05}; run("R4", 0, 2, 0);
        // R3: set latch
        tx_q = '{8'h06}; run("R3", 0, 0, 0);
        tx_q = '{8'h05}; run("R3", 0, 1, 0);
        // R5/R9: aligned write commits
        tx_q = '{8'h02, 8'h00, 8'h05, 8'h11, 8'h22, 8'h33}; run("R9", 0, 0, 1);
        tx_q = '{8'h05}; run("R5", 0, 1, 0);
        tx_q = '{8'h03, 8'h00, 8'h05}; run("R6", 0, 3, 0);
        // R5: misaligned write discarded, latch kept
        tx_q = '{8'h06}; run("R3", 0, 0, 0);
        tx_q = '{8'h02, 8'h00, 8'h08, 8'h44}; run("R5", 3, 0, 1);
        tx_q = '{8'h05}; run("R5", 0, 1, 0);
        tx_q = '{8'h03, 8'h00, 8'h08}; run("R5", 0, 1, 0);
        // R3: clear latch
        tx_q = '{8'h04}; run("R3", 0, 0, 0);
        tx_q = '{8'h05}; run("R3", 0, 1, 0);
        // R2: bit 3 ignored, upper nibble rejected, unknown code rejected
        tx_q = '{8'h0E}; run("R2", 0, 0, 0);
        tx_q = '{8'h05}; run("R2", 0, 1, 0);
        tx_q = '{8'h04}; run("R2", 0, 0, 0);
        tx_q = '{8'h86}; run("R2", 0, 1, 0);
        tx_q = '{8'h07}; run("R2", 0, 1, 0);
        tx_q = '{8'h0D}; run("R2", 0, 1, 0);
        // R8: status write changes only bits 7,3,2
        tx_q = '{8'h06}; run("R8", 0, 0, 0);
        tx_q = '{8'h01, 8'hFF}; run("R8", 0, 0, 1);
        tx_q = '{8'h05}; run("R8", 0, 1, 0);
        // R10: opcodes during busy
        tx_q = '{8'h06}; run("R10", 0, 0, 0);
        tx_q = '{8'h02, 8'h00, 8'h3E, 8'h5A, 8'hA5}; run("R10", 0, 0, 0);
        chk("R9", "busy_now", busy, 1);
        tx_q = '{8'h05}; run("R9", 0, 1, 0);
        tx_q = '{8'h06}; run("R10", 0, 0, 0);
        tx_q = '{8'h03, 8'h00, 8'h00}; run("R10", 0, 1, 0);
        wait_idle();
        tx_q = '{8'h05}; run("R10", 0, 1, 0);
        // R6: wrap across the top, upper address bits ignored
        tx_q = '{8'h03, 8'h00, 8'h3E}; run("R6", 0, 4, 0);
        tx_q = '{8'h03, 8'hFF, 8'hC5}; run("R6", 0, 2, 0);
        // R11: page overflow
        tx_q = '{8'h06}; run("R11", 0, 0, 0);
        tx_q = '{8'h02, 8'h00, 8'h10, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05,
                 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A};
        run("R11", 0, 0, 1);
        tx_q = '{8'h03, 8'h00, 8'h10}; run("R11", 0, 10, 0);
        // R7: repeated status stream
        tx_q = '{8'h05}; run("R7", 0, 3, 0);
        // R8: masked bits in the written byte
        tx_q = '{8'h06}; run("R8", 0, 0, 0);
        tx_q = '{8'h01, 8'hF3}; run("R8", 0, 0, 1);
        tx_q = '{8'h05}; run("R8", 0, 2, 0);
        // R12: output enable idle after all traffic
        chk("R12", "so_oe_idle", so_oe, 0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule